// File: doc/BRIEF.md
# Complex CIC Interpolator with Run-Time Ratio

This block raises the sample rate of a complex baseband stream (an in-phase and a quadrature channel, 12-bit signed each) by an integer ratio chosen at run time between 2 and 63. Each channel passes through a four-stage cascaded integrator-comb filter with a differential delay of one. The combs run once per accepted input sample. Each filtered sample is then followed by ratio-minus-one zero samples, and the whole sequence feeds the four integrators, which run once per output sample. The block is meant to follow a stage that has already upsampled the baseband data by at least two, because the passband droop of the filter would otherwise reach into the signal band.

The filter gain is the cube of the ratio. The integrator output is divided by the next power of two at or above that gain, using an arithmetic right shift, and is then clamped to 12 bits. Power-of-two ratios therefore have exactly unity DC gain, and other ratios lose a little level, by an amount that depends on the ratio. Both the input and the output are valid/ready streams. A transfer happens on a clock edge where valid and ready are both high. A producer that sees ready low keeps its sample and waits. A consumer that holds `out_ready` low stalls the whole filter, and no data is lost or repeated.

Top module: `cic_interp_iq`

## Requirements
- R1: Every accepted input sample produces exactly R output transfers, where R is the active ratio. The first output carries the comb-filtered sample, and the next R-1 outputs carry zero-stuffed integrator updates.
- R2: For each channel, the output sequence equals a four-stage, unit-delay comb-then-integrator interpolation of the input with zero stuffing. Each integrator output is shifted right arithmetically by ceil(log2(R^3)) bits and clamped to the signed 12-bit range [-2048, 2047]. `out_i` carries the in-phase channel and `out_q` the quadrature channel.
- R3: With a power-of-two ratio, a constant input settles to an output exactly equal to the input (for example R=8, input -700 gives -700).
- R4: With a ratio that is not a power of two, a constant input x settles to floor(x·R^3 / 2^ceil(log2 R^3)). For example, R=3 with 1024 gives 864, and R=5 with 1000 gives 976 and with -1000 gives -977.
- R5: `in_ready` is high only when no zero-stuffed outputs of the previous sample are still owed, the output register is empty or is being drained in the same cycle, and no ratio change is pending.
- R6: Once `out_valid` is high, it stays high and `out_i`/`out_q` stay unchanged until a cycle with `out_ready` high.
- R7: A new value on `rate_sel` is adopted only when no zero-stuffed outputs are owed. The cycle that adopts it clears every comb and integrator register and holds `in_ready` low. Outputs already owed for a sample keep the old ratio.
- R8: A `rate_sel` value below 2 is treated as 2.
- R9: During and right after reset, `out_valid` is low, all filter state is zero and the active ratio is 2. With `rate_sel` at 2, `in_ready` is high in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 6 | Requested interpolation ratio |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Input sample can be taken this cycle |
| in_i | input | 12 | In-phase input sample, signed |
| in_q | input | 12 | Quadrature input sample, signed |
| out_valid | output | 1 | Output sample held in the output register |
| out_ready | input | 1 | Consumer takes the output sample this cycle |
| out_i | output | 12 | In-phase output sample, signed |
| out_q | output | 12 | Quadrature output sample, signed |

## Verification
The properties assume that `out_ready` may toggle freely and that the active ratio is the only internal state they need. Each property compares the output transfers against a count of owed samples that is built from accepted inputs and the ratio in force when each input was accepted. They also assume that `rate_sel` can change in any cycle. The stimulus respects this: it moves `rate_sel` both while outputs are still owed and after the stream has drained. It keeps each offered sample steady until it is accepted, and it applies random, constant and fully stalled back-pressure on the output side.

// File: rtl/cic_pkg.sv
package cic_pkg;

  // Number of integrator and comb sections per channel.
  localparam int unsigned CIC_STAGES = 4;

  // Smallest s such that 2**s >= r**3, i.e. the gain normalisation shift.
  function automatic int unsigned cube_log2(input int unsigned r);
    longint unsigned c;
    int unsigned     s;
    c = longint'(r) * longint'(r) * longint'(r);
    s = 0;
    for (int k = 0; k < 48; k++) begin
      if ((longint'(1) << s) < c) s++;
    end
    return s;
  endfunction

endpackage

// File: rtl/cic_comb_chain.sv
module cic_comb_chain #(
  parameter int unsigned IW = 12,
  parameter int unsigned AW = 36,
  parameter int unsigned NS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 en,
  input  logic signed [IW-1:0] x,
  output logic signed [AW-1:0] y
);

  logic signed [AW-1:0] tap [0:NS];

  assign tap[0] = {{(AW-IW){x[IW-1]}}, x};

  generate
    for (genvar k = 0; k < NS; k++) begin : g_sec
      logic signed [AW-1:0] dly_q;
      // y[n] = x[n] - x[n-1], one update per low-rate sample
      assign tap[k+1] = tap[k] - dly_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   dly_q <= '0;
        else if (clr) dly_q <= '0;
        else if (en)  dly_q <= tap[k];
      end
    end
  endgenerate

  assign y = tap[NS];

endmodule

// File: rtl/cic_integ_chain.sv
module cic_integ_chain #(
  parameter int unsigned AW = 36,
  parameter int unsigned NS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 en,
  input  logic signed [AW-1:0] x,
  output logic signed [AW-1:0] y
);

  logic signed [AW-1:0] tap [0:NS];

  assign tap[0] = x;

  generate
    for (genvar k = 0; k < NS; k++) begin : g_sec
      logic signed [AW-1:0] acc_q;
      // y[n] = y[n-1] + x[n], one update per high-rate sample
      assign tap[k+1] = acc_q + tap[k];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   acc_q <= '0;
        else if (clr) acc_q <= '0;
        else if (en)  acc_q <= tap[k+1];
      end
    end
  endgenerate

  assign y = tap[NS];

endmodule

// File: rtl/cic_scale_sat.sv
module cic_scale_sat #(
  parameter int unsigned AW = 36,
  parameter int unsigned OW = 12,
  parameter int unsigned SW = 5
) (
  input  logic signed [AW-1:0] acc,
  input  logic        [SW-1:0] shamt,
  output logic signed [OW-1:0] y
);

  localparam logic signed [AW-1:0] POS_LIM = {{(AW-OW+1){1'b0}}, {(OW-1){1'b1}}};
  localparam logic signed [AW-1:0] NEG_LIM = {{(AW-OW+1){1'b1}}, {(OW-1){1'b0}}};

  logic signed [AW-1:0] shifted;

  always_comb begin
    shifted = acc >>> shamt;
    if (shifted > POS_LIM)      y = POS_LIM[OW-1:0];
    else if (shifted < NEG_LIM) y = NEG_LIM[OW-1:0];
    else                        y = shifted[OW-1:0];
  end

endmodule

// File: rtl/cic_interp_iq.sv
module cic_interp_iq
  import cic_pkg::*;
#(
  parameter int unsigned DW   = 12,
  parameter int unsigned RMIN = 2,
  parameter int unsigned RMAX = 63,
  localparam int unsigned RW    = $clog2(RMAX + 1),
  localparam int unsigned AW    = DW + CIC_STAGES * $clog2(RMAX),
  localparam int unsigned SHMAX = cube_log2(RMAX),
  localparam int unsigned SW    = $clog2(SHMAX + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [RW-1:0]        rate_sel,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q
);

  localparam int unsigned NCH = 2;

  logic [RW-1:0]       ratio_q;
  logic [SW-1:0]       shamt_q;
  logic [RW-1:0]       left_q;
  logic                ovld_q;
  logic [NCH*DW-1:0]   obus_q;

  logic [RW-1:0]       rate_eff;
  logic [SW-1:0]       shamt_nxt;
  logic                reconf;
  logic                slot_free;
  logic                in_fire;
  logic                step;
  logic [NCH*DW-1:0]   ibus;
  logic [NCH*DW-1:0]   sbus;

  // Requested ratio, floored at the minimum and capped at the maximum.
  always_comb begin
    if (rate_sel < RW'(RMIN))                        rate_eff = RW'(RMIN);
    else if ({1'b0, rate_sel} > (RW+1)'(RMAX))       rate_eff = RW'(RMAX);
    else                                             rate_eff = rate_sel;
    shamt_nxt = SW'(cube_log2(32'(rate_eff)));
  end

  assign reconf    = (left_q == '0) && (rate_eff != ratio_q);
  assign slot_free = !ovld_q || out_ready;
  assign in_ready  = slot_free && (left_q == '0) && !reconf;
  assign in_fire   = in_valid && in_ready;
  assign step      = in_fire || (slot_free && (left_q != '0));
  assign ibus      = {in_q, in_i};

  generate
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      logic signed [AW-1:0] comb_y;
      logic signed [AW-1:0] integ_x;
      logic signed [AW-1:0] integ_y;
      logic signed [DW-1:0] scaled;

      cic_comb_chain #(.IW(DW), .AW(AW), .NS(CIC_STAGES)) u_comb (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (reconf),
        .en    (in_fire),
        .x     (ibus[ch*DW +: DW]),
        .y     (comb_y)
      );

      // zero stuffing between low-rate samples
      assign integ_x = in_fire ? comb_y : '0;

      cic_integ_chain #(.AW(AW), .NS(CIC_STAGES)) u_integ (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (reconf),
        .en    (step),
        .x     (integ_x),
        .y     (integ_y)
      );

      cic_scale_sat #(.AW(AW), .OW(DW), .SW(SW)) u_scale (
        .acc   (integ_y),
        .shamt (shamt_q),
        .y     (scaled)
      );

      assign sbus[ch*DW +: DW] = scaled;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q <= RW'(RMIN);
      shamt_q <= SW'(cube_log2(RMIN));
      left_q  <= '0;
      ovld_q  <= 1'b0;
      obus_q  <= '0;
    end else begin
      if (reconf) begin
        ratio_q <= rate_eff;
        shamt_q <= shamt_nxt;
      end
      if (in_fire)   left_q <= ratio_q - RW'(1);
      else if (step) left_q <= left_q - RW'(1);
      if (step) begin
        ovld_q <= 1'b1;
        obus_q <= sbus;
      end else if (out_ready) begin
        ovld_q <= 1'b0;
      end
    end
  end

  assign out_valid = ovld_q;
  assign out_i     = obus_q[DW-1:0];
  assign out_q     = obus_q[NCH*DW-1:DW];

endmodule

// File: rtl/cic_interp_chk.sv
module cic_interp_chk #(
  parameter int unsigned DW   = 12,
  parameter int unsigned RW   = 6,
  parameter int unsigned RMAX = 63
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic signed [DW-1:0] out_i,
  input logic signed [DW-1:0] out_q,
  input logic [RW-1:0]        ratio
);

  logic       in_fire;
  logic       out_fire;
  logic [9:0] owed_q;

  assign in_fire  = in_valid && in_ready;
  assign out_fire = out_valid && out_ready;

  // outputs promised by accepted inputs and not yet transferred
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owed_q <= '0;
    else        owed_q <= owed_q + (in_fire ? 10'(ratio) : 10'd0) - (out_fire ? 10'd1 : 10'd0);
  end

  assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_i) && $stable(out_q));

  assert_no_extra_out_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire |-> owed_q != '0);

  assert_accept_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |-> owed_q <= 10'd1);

  assert_ready_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!out_valid || out_ready));

  assert_ratio_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ratio >= RW'(2) && {1'b0, ratio} <= (RW+1)'(RMAX));

  assert_ratio_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio != $past(ratio)) |-> $past(owed_q) <= 10'd1);

endmodule

bind cic_interp_iq cic_interp_chk #(.DW(DW), .RW(RW), .RMAX(RMAX)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_i     (out_i),
  .out_q     (out_q),
  .ratio     (ratio_q)
);

// File: tb/sim_cic_interp_iq.sv
module sim_cic_interp_iq;

  localparam int CLK_P = 10;
  localparam int DW    = 12;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [5:0]           rate_sel = 6'd2;
  logic                 in_valid = 1'b0;
  logic                 in_ready;
  logic signed [DW-1:0] in_i = '0;
  logic signed [DW-1:0] in_q = '0;
  logic                 out_valid;
  logic                 out_ready = 1'b0;
  logic signed [DW-1:0] out_i;
  logic signed [DW-1:0] out_q;

  always #(CLK_P/2) clk = ~clk;

  cic_interp_iq u0 (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_ready(out_ready), .out_i(out_i), .out_q(out_q)
  );

  int           checks = 0;
  int           fails = 0;
  logic [23:0]  expq[$];
  longint       md[2][4];
  longint       ma[2][4];
  int           mr = 2;
  int           bp_mode = 1;
  int           got = 0;
  int           last_i = 0;
  int           last_q = 0;
  logic [15:0]  lfsr = 16'hACE1;
  string        cur_req = "R2";

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int shift_for(input int r);
    int s = 0;
    while ((longint'(1) << s) < longint'(r) * r * r) s++;
    return s;
  endfunction

  function automatic longint clamp12(input longint v);
    if (v > 2047)  return 2047;
    if (v < -2048) return -2048;
    return v;
  endfunction

  task automatic mdl_clear(input int r);
    mr = r;
    for (int ch = 0; ch < 2; ch++)
      for (int k = 0; k < 4; k++) begin
        md[ch][k] = 0;
        ma[ch][k] = 0;
      end
  endtask

  // scoreboard driver side: expected items from the filter definition
  task automatic mdl_push(input longint xi, input longint xq);
    longint c[2];
    longint v[2];
    longint t;
    int     sh;
    sh = shift_for(mr);
    c[0] = xi;
    c[1] = xq;
    for (int ch = 0; ch < 2; ch++)
      for (int k = 0; k < 4; k++) begin
        t = c[ch] - md[ch][k];
        md[ch][k] = c[ch];
        c[ch] = t;
      end
    for (int p = 0; p < mr; p++) begin
      for (int ch = 0; ch < 2; ch++) begin
        v[ch] = (p == 0) ? c[ch] : 0;
        for (int k = 0; k < 4; k++) begin
          ma[ch][k] = ma[ch][k] + v[ch];
          v[ch] = ma[ch][k];
        end
      end
      expq.push_back({12'(clamp12(v[1] >>> sh)), 12'(clamp12(v[0] >>> sh))});
    end
  endtask

  task automatic send(input int xi, input int xq);
    @(negedge clk);
    in_valid = 1'b1;
    in_i = 12'(xi);
    in_q = 12'(xq);
    forever begin
      #(CLK_P/4);
      if (in_ready) break;
      @(negedge clk);
    end
    mdl_push(xi, xq);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // scoreboard monitor side
  initial begin
    logic [23:0] e;
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (bp_mode)
        0:       out_ready = lfsr[0] | lfsr[5];
        1:       out_ready = 1'b1;
        default: out_ready = 1'b0;
      endcase
      #(CLK_P/4);
      if (rst_n && out_valid && out_ready) begin
        if (expq.size() == 0) begin
          check(1'b0, "R1 unexpected output", {out_q, out_i}, 0);
        end else begin
          e = expq.pop_front();
          check({out_q, out_i} == e, cur_req, {out_q, out_i}, e);
          got++;
          last_i = int'(out_i);
          last_q = int'(out_q);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic signed [DW-1:0] held;
    repeat (3) @(negedge clk);
    #(CLK_P/4);
    check(out_valid == 1'b0, "R9 out_valid in reset", out_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #(CLK_P/4);
    check(in_ready == 1'b1, "R9 in_ready after reset", in_ready, 1);
    check(out_valid == 1'b0, "R9 out_valid after reset", out_valid, 0);
    mdl_clear(2);

    // R2: varied samples, random back-pressure, ratio 2
    cur_req = "R2 ratio 2";
    bp_mode = 0;
    got = 0;
    for (int k = 0; k < 20; k++) send((k * 397) % 4096 - 2048, 1500 - (k * 211) % 3000);
    drain();
    check(got == 40, "R1 count ratio 2", got, 40);

    // R7 + R3: move to ratio 8, clear cycle, then constant input
    @(negedge clk);
    rate_sel = 6'd8;
    #(CLK_P/4);
    check(in_ready == 1'b0, "R7 ready low on ratio change", in_ready, 0);
    mdl_clear(8);
    cur_req = "R3 ratio 8";
    got = 0;
    for (int k = 0; k < 12; k++) send(-700, 1500);
    drain();
    check(last_i == -700, "R3 unity gain I", last_i, -700);
    check(last_q == 1500, "R3 unity gain Q", last_q, 1500);
    check(got == 96, "R1 count ratio 8", got, 96);

    // R4: ratio 3
    @(negedge clk);
    rate_sel = 6'd3;
    mdl_clear(3);
    cur_req = "R4 ratio 3";
    for (int k = 0; k < 10; k++) send(1024, 0);
    drain();
    check(last_i == 864, "R4 ratio 3 gain", last_i, 864);

    // R4: ratio 5
    @(negedge clk);
    rate_sel = 6'd5;
    mdl_clear(5);
    cur_req = "R4 ratio 5";
    for (int k = 0; k < 10; k++) send(1000, -1000);
    drain();
    check(last_i == 976, "R4 ratio 5 gain I", last_i, 976);
    check(last_q == -977, "R4 ratio 5 gain Q", last_q, -977);

    // R7: state left by the constant run must be cleared on change to 4
    @(negedge clk);
    rate_sel = 6'd4;
    mdl_clear(4);
    cur_req = "R7 cleared impulse";
    send(512, -512);
    for (int k = 0; k < 5; k++) send(0, 0);
    drain();

    // R5/R6: stall the output, then move rate_sel while outputs are owed
    bp_mode = 2;
    cur_req = "R7 old ratio kept";
    got = 0;
    send(100, -100);
    @(negedge clk);
    #(CLK_P/4);
    check(out_valid == 1'b1, "R6 output presented", out_valid, 1);
    check(in_ready == 1'b0, "R5 ready low while stalled", in_ready, 0);
    held = out_i;
    @(negedge clk);
    rate_sel = 6'd6;
    #(CLK_P/4);
    check(out_i == held && out_valid, "R6 output held", out_i, held);
    check(in_ready == 1'b0, "R7 no accept while owed", in_ready, 0);
    bp_mode = 0;
    drain();
    check(got == 4, "R7 owed outputs at old ratio", got, 4);
    mdl_clear(6);
    cur_req = "R2 ratio 6";
    for (int k = 0; k < 6; k++) send(k * 300 - 800, 700 - k * 250);
    drain();

    // R8: a value below two acts as two
    @(negedge clk);
    rate_sel = 6'd0;
    mdl_clear(2);
    cur_req = "R8 ratio 0 as 2";
    got = 0;
    for (int k = 0; k < 5; k++) send(300 + k, -300);
    drain();
    check(got == 10, "R8 count", got, 10);

    // R2: largest ratio, full-scale alternating input
    @(negedge clk);
    rate_sel = 6'd63;
    mdl_clear(63);
    cur_req = "R2 ratio 63";
    got = 0;
    for (int k = 0; k < 6; k++) send((k % 2 == 0) ? 2047 : -2048, (k % 2 == 0) ? -2048 : 2047);
    drain();
    check(got == 378, "R1 count ratio 63", got, 378);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule